// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block holds a small set of waiting operations in front of one functional unit class. Each accepted operation takes a free slot. Each of its two sources arrives either as a value or as the tag of the station that will produce it. Waiting slots watch a shared result bus that carries a 4-bit producer tag and 64 bits of data. When a slot sees the tag it is waiting on, it copies the data and stops waiting. Operations therefore leave the pool in the order their operands become available, not in the order they arrived.

A slot whose sources are both present can be dispatched to the single execution unit behind the pool. That unit is a fixed-latency counter with an integer stand-in operation. When the unit finishes, it raises a completion request carrying the result and the slot's own tag. It holds that request until an external arbiter grants the bus, and only then is the slot released. An issue is refused while every slot is occupied.

Top module: `rs_pool`

## Requirements
- R1: After reset, `issueReady` is 1, and `dispValid` and `resultReq` are both 0.
- R2: An issue is accepted when `issueValid` and `issueReady` are both high at a clock edge. It goes into the lowest-numbered free slot, and slot i carries tag `TAG_BASE + i` (tags 1, 2 and 3 by default). With every slot busy, `issueReady` is 0 and an issue attempt is dropped with no effect.
- R3: A source tag of 0 means the value given with it is valid. A slot with both tags 0 dispatches in the cycle right after its issue edge while the unit is idle, and `dispTag` shows that slot's tag.
- R4: A source with a nonzero tag waits. When `busValid` is high and `busTag` equals that tag, the slot copies `busData` into that source. The slot may dispatch in the cycle after that edge.
- R5: If the result bus carries a tag matching an issuing source's tag at the same edge as the issue, the data is captured at issue.
- R6: When several slots are ready at once, the one issued earliest dispatches first, whatever its slot number.
- R7: Only one operation is in the unit at a time. `resultReq` rises `EXEC_LAT` (default 2) clock edges after the dispatch edge. No dispatch occurs while an operation is executing or waiting for the bus.
- R8: `resultReq`, `resultTag` and `resultData` stay constant until `busGrant` is high at an edge. At that edge the request drops and the slot is freed, so a full pool shows `issueReady` = 1 in the next cycle.
- R9: The 2-bit opcode selects the result: 0 is A+B, 1 is A-B, 2 is A AND B, 3 is A OR B. Arithmetic is 64-bit and wraps modulo 2^64.
- R10: A broadcast whose tag matches no waiting source changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | 2 | Opcode |
| issueTagA | input | 4 | Producer tag of source A, 0 when the value is valid |
| issueValA | input | 64 | Value of source A |
| issueTagB | input | 4 | Producer tag of source B, 0 when the value is valid |
| issueValB | input | 64 | Value of source B |
| issueReady | output | 1 | At least one slot is free |
| busValid | input | 1 | Result bus carries a result |
| busTag | input | 4 | Tag of the producing station on the bus |
| busData | input | 64 | Result bus data |
| dispValid | output | 1 | A slot is dispatched at the coming edge |
| dispTag | output | 4 | Tag of the dispatched slot |
| resultReq | output | 1 | Completion request for the result bus |
| resultTag | output | 4 | Tag of the completing slot |
| resultData | output | 64 | Completed result |
| busGrant | input | 1 | Result bus granted to this pool |

## Verification
An issue or a matching broadcast at edge E shows up as `dispValid` in the cycle after E. `resultReq` then rises after edge E+1+`EXEC_LAT`, which is three cycles after E by default. A grant at edge G drops the request and frees the slot, both visible after G. The bench changes inputs on falling edges and reads outputs on the following falling edge, so each expected value is compared in the exact cycle the count above predicts. Where a result only has to arrive eventually, a bounded poll is used instead.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 4;
  localparam int IDX_W  = 4;  // a 4-bit tag space limits a pool to 15 slots

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } rs_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXEC = 2'd1,
    S_DONE = 2'd2
  } exec_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             allocEn;
    logic [IDX_W-1:0] allocIdx;
    logic             dispEn;
    logic [IDX_W-1:0] dispIdx;
  } rs_ctrl_t;
endpackage

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pool_pkg::*;
#(
  parameter int NUM_ENTRIES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rs_ctrl_t               ctrl,
  input  logic [1:0]             issueOp,
  input  logic [TAG_W-1:0]       issueTagA,
  input  logic [DATA_W-1:0]      issueValA,
  input  logic [TAG_W-1:0]       issueTagB,
  input  logic [DATA_W-1:0]      issueValB,
  input  logic                   busValid,
  input  logic [TAG_W-1:0]       busTag,
  input  logic [DATA_W-1:0]      busData,
  output logic [NUM_ENTRIES-1:0] readyVec,
  output logic [DATA_W-1:0]      resultData
);

  rs_op_e            opArr   [NUM_ENTRIES];
  logic [DATA_W-1:0] valAArr [NUM_ENTRIES];
  logic [DATA_W-1:0] valBArr [NUM_ENTRIES];

  // a tag that is also on the bus this cycle is captured at issue
  logic issueHitA, issueHitB;
  assign issueHitA = busValid && (busTag == issueTagA);
  assign issueHitB = busValid && (busTag == issueTagB);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    rs_op_e            opR;
    logic [DATA_W-1:0] valA, valB;
    logic [TAG_W-1:0]  tagA, tagB;
    logic              writeSel, snoopA, snoopB;

    assign writeSel = ctrl.allocEn && (ctrl.allocIdx == IDX_W'(e));
    assign snoopA   = busValid && (tagA != '0) && (busTag == tagA);
    assign snoopB   = busValid && (tagB != '0) && (busTag == tagB);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opR  <= OP_ADD;
        valA <= '0;
        valB <= '0;
        tagA <= '0;
        tagB <= '0;
      end else if (writeSel) begin
        opR <= rs_op_e'(issueOp);
        if (issueTagA == '0) begin
          valA <= issueValA;
          tagA <= '0;
        end else if (issueHitA) begin
          valA <= busData;
          tagA <= '0;
        end else begin
          tagA <= issueTagA;
        end
        if (issueTagB == '0) begin
          valB <= issueValB;
          tagB <= '0;
        end else if (issueHitB) begin
          valB <= busData;
          tagB <= '0;
        end else begin
          tagB <= issueTagB;
        end
      end else begin
        if (snoopA) begin
          valA <= busData;
          tagA <= '0;
        end
        if (snoopB) begin
          valB <= busData;
          tagB <= '0;
        end
      end
    end

    assign readyVec[e] = (tagA == '0) && (tagB == '0);
    assign opArr[e]    = opR;
    assign valAArr[e]  = valA;
    assign valBArr[e]  = valB;
  end

  // operand select for the dispatched slot
  rs_op_e            selOp;
  logic [DATA_W-1:0] selA, selB;

  always_comb begin
    selOp = OP_ADD;
    selA  = '0;
    selB  = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (ctrl.dispIdx == IDX_W'(e)) begin
        selOp = opArr[e];
        selA  = valAArr[e];
        selB  = valBArr[e];
      end
    end
  end

  // stand-in execution: result formed at dispatch, held until the next one
  logic [DATA_W-1:0] resR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resR <= '0;
    end else if (ctrl.dispEn) begin
      unique case (selOp)
        OP_ADD:  resR <= selA + selB;
        OP_SUB:  resR <= selA - selB;
        OP_AND:  resR <= selA & selB;
        default: resR <= selA | selB;
      endcase
    end
  end

  assign resultData = resR;

endmodule

// File: rtl/rs_control.sv
module rs_control
  import rs_pool_pkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int TAG_BASE    = 1,
  parameter int EXEC_LAT    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  input  logic [NUM_ENTRIES-1:0] readyVec,
  input  logic                   busGrant,
  output rs_ctrl_t               ctrl,
  output logic                   issueReady,
  output logic                   dispValid,
  output logic [TAG_W-1:0]       dispTag,
  output logic                   resultReq,
  output logic [TAG_W-1:0]       resultTag
);

  localparam int CNT_W = (EXEC_LAT > 1) ? $clog2(EXEC_LAT) : 1;

  logic [NUM_ENTRIES-1:0] busy;
  logic [NUM_ENTRIES-1:0] older [NUM_ENTRIES];  // older[j][i]: j issued before i
  exec_state_e            state;
  logic [CNT_W-1:0]       cnt;
  logic [IDX_W-1:0]       execIdx;

  // lowest free slot
  logic             allocFound;
  logic [IDX_W-1:0] allocIdx;

  always_comb begin
    allocFound = 1'b0;
    allocIdx   = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (!busy[e]) begin
        allocFound = 1'b1;
        allocIdx   = IDX_W'(e);
      end
    end
  end

  // oldest ready slot
  logic [NUM_ENTRIES-1:0] cand, win;
  logic                   dispFound;
  logic [IDX_W-1:0]       dispIdx;

  always_comb begin
    cand = busy & readyVec;
    win  = cand;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (i != j && cand[j] && older[j][i]) win[i] = 1'b0;
      end
    end
    dispFound = 1'b0;
    dispIdx   = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (win[e]) begin
        dispFound = 1'b1;
        dispIdx   = IDX_W'(e);
      end
    end
  end

  assign ctrl.allocEn  = issueValid && allocFound;
  assign ctrl.allocIdx = allocIdx;
  assign ctrl.dispEn   = (state == S_IDLE) && dispFound;
  assign ctrl.dispIdx  = dispIdx;

  logic freeEn;
  assign freeEn = (state == S_DONE) && busGrant;

  // occupancy and issue age
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) older[e] <= '0;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (freeEn && execIdx == IDX_W'(e)) busy[e] <= 1'b0;
        if (ctrl.allocEn && allocIdx == IDX_W'(e)) begin
          busy[e]  <= 1'b1;
          older[e] <= '0;
          for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (k != e) older[k][e] <= busy[k];
          end
        end
      end
    end
  end

  // execution unit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      execIdx <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (ctrl.dispEn) begin
          state   <= S_EXEC;
          cnt     <= CNT_W'(EXEC_LAT - 1);
          execIdx <= dispIdx;
        end
        S_EXEC: if (cnt == '0) state <= S_DONE;
                else cnt <= cnt - 1'b1;
        S_DONE: if (busGrant) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign issueReady = allocFound;
  assign dispValid  = ctrl.dispEn;
  assign dispTag    = TAG_W'(TAG_BASE) + TAG_W'(dispIdx);
  assign resultReq  = (state == S_DONE);
  assign resultTag  = TAG_W'(TAG_BASE) + TAG_W'(execIdx);

endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int TAG_BASE    = 1,
  parameter int EXEC_LAT    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [1:0]  issueOp,
  input  logic [3:0]  issueTagA,
  input  logic [63:0] issueValA,
  input  logic [3:0]  issueTagB,
  input  logic [63:0] issueValB,
  output logic        issueReady,
  input  logic        busValid,
  input  logic [3:0]  busTag,
  input  logic [63:0] busData,
  output logic        dispValid,
  output logic [3:0]  dispTag,
  output logic        resultReq,
  output logic [3:0]  resultTag,
  output logic [63:0] resultData,
  input  logic        busGrant
);

  rs_ctrl_t               ctrl;
  logic [NUM_ENTRIES-1:0] readyVec;

  rs_control #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .TAG_BASE   (TAG_BASE),
    .EXEC_LAT   (EXEC_LAT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .readyVec  (readyVec),
    .busGrant  (busGrant),
    .ctrl      (ctrl),
    .issueReady(issueReady),
    .dispValid (dispValid),
    .dispTag   (dispTag),
    .resultReq (resultReq),
    .resultTag (resultTag)
  );

  rs_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .issueOp   (issueOp),
    .issueTagA (issueTagA),
    .issueValA (issueValA),
    .issueTagB (issueTagB),
    .issueValB (issueValB),
    .busValid  (busValid),
    .busTag    (busTag),
    .busData   (busData),
    .readyVec  (readyVec),
    .resultData(resultData)
  );

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NUM_ENTRIES = 3,
  parameter int TAG_BASE    = 1,
  parameter int EXEC_LAT    = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic        issueReady,
  input logic        dispValid,
  input logic [3:0]  dispTag,
  input logic        resultReq,
  input logic [3:0]  resultTag,
  input logic [63:0] resultData,
  input logic        busGrant
);

  // cycles since the last dispatch, saturating
  logic [7:0] sinceDisp;
  always_ff @(posedge clk) begin
    if (!rstN) sinceDisp <= '0;
    else if (dispValid) sinceDisp <= '0;
    else if (sinceDisp != 8'hFF) sinceDisp <= sinceDisp + 8'd1;
  end

  p_full_by_issue_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(issueReady) |-> $past(issueValid));

  p_disp_tag_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (dispTag >= 4'(TAG_BASE)) && (dispTag < 4'(TAG_BASE + NUM_ENTRIES)));

  p_single_exec_r7: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> !resultReq);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultReq) |-> sinceDisp == 8'(EXEC_LAT));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    resultReq && !busGrant |=> resultReq && $stable(resultTag) && $stable(resultData));

  p_grant_frees_r8: assert property (@(posedge clk) disable iff (!rstN)
    resultReq && busGrant |=> issueReady && !resultReq);

endmodule

bind rs_pool rs_pool_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .TAG_BASE   (TAG_BASE),
  .EXEC_LAT   (EXEC_LAT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueReady(issueReady),
  .dispValid (dispValid),
  .dispTag   (dispTag),
  .resultReq (resultReq),
  .resultTag (resultTag),
  .resultData(resultData),
  .busGrant  (busGrant)
);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [1:0]  issueOp;
  logic [3:0]  issueTagA, issueTagB;
  logic [63:0] issueValA, issueValB;
  logic        issueReady;
  logic        busValid;
  logic [3:0]  busTag;
  logic [63:0] busData;
  logic        dispValid;
  logic [3:0]  dispTag;
  logic        resultReq;
  logic [3:0]  resultTag;
  logic [63:0] resultData;
  logic        busGrant;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;  // 250 MHz

  rs_pool dut (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueTagA(issueTagA), .issueValA(issueValA),
    .issueTagB(issueTagB), .issueValB(issueValB),
    .issueReady(issueReady),
    .busValid(busValid), .busTag(busTag), .busData(busData),
    .dispValid(dispValid), .dispTag(dispTag),
    .resultReq(resultReq), .resultTag(resultTag), .resultData(resultData),
    .busGrant(busGrant)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic setIssue(input logic [1:0] op, input logic [3:0] ta, input logic [63:0] va,
                          input logic [3:0] tb, input logic [63:0] vb);
    issueValid = 1'b1; issueOp = op;
    issueTagA = ta; issueValA = va; issueTagB = tb; issueValB = vb;
  endtask

  task automatic doIssue(input logic [1:0] op, input logic [3:0] ta, input logic [63:0] va,
                         input logic [3:0] tb, input logic [63:0] vb);
    setIssue(op, ta, va, tb, vb);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic broadcast(input logic [3:0] t, input logic [63:0] d);
    busValid = 1'b1; busTag = t; busData = d;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic awaitResult(input logic [3:0] expTag, input logic [63:0] expData, input string req);
    for (int n = 0; n < 20; n++) begin
      if (resultReq) break;
      @(negedge clk);
    end
    check(resultReq == 1'b1, req, 64'(resultReq), 64'd1);
    check(resultTag == expTag, req, 64'(resultTag), 64'(expTag));
    check(resultData == expData, req, resultData, expData);
  endtask

  task automatic grant();
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
    check(resultReq == 1'b0, "R8 request drops on grant", 64'(resultReq), 64'd0);
  endtask

  task automatic testReset();
    check(issueReady == 1'b1, "R1 issueReady", 64'(issueReady), 64'd1);
    check(dispValid == 1'b0, "R1 dispValid", 64'(dispValid), 64'd0);
    check(resultReq == 1'b0, "R1 resultReq", 64'(resultReq), 64'd0);
  endtask

  task automatic testBasicTiming();
    doIssue(2'd0, 4'd0, 64'd5, 4'd0, 64'd7);
    check(dispValid == 1'b1, "R3 dispatch after issue", 64'(dispValid), 64'd1);
    check(dispTag == 4'd1, "R3 dispTag of slot 0", 64'(dispTag), 64'd1);
    @(negedge clk);
    check(dispValid == 1'b0 && resultReq == 1'b0, "R7 executing", 64'({dispValid, resultReq}), 64'd0);
    @(negedge clk);
    check(resultReq == 1'b0, "R7 not before latency", 64'(resultReq), 64'd0);
    @(negedge clk);
    check(resultReq == 1'b1, "R7 result after latency", 64'(resultReq), 64'd1);
    check(resultTag == 4'd1, "R7 result tag", 64'(resultTag), 64'd1);
    check(resultData == 64'd12, "R9 add", resultData, 64'd12);
    repeat (2) @(negedge clk);
    check(resultReq == 1'b1 && resultTag == 4'd1 && resultData == 64'd12,
          "R8 held without grant", resultData, 64'd12);
    grant();
  endtask

  task automatic testOps();
    doIssue(2'd1, 4'd0, 64'd10, 4'd0, 64'd3);
    awaitResult(4'd1, 64'd7, "R9 sub");
    grant();
    doIssue(2'd1, 4'd0, 64'd0, 4'd0, 64'd1);
    awaitResult(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R9 sub wraps");
    grant();
    doIssue(2'd2, 4'd0, 64'hF0, 4'd0, 64'h3C);
    awaitResult(4'd1, 64'h30, "R9 and");
    grant();
    doIssue(2'd3, 4'd0, 64'hF0, 4'd0, 64'h0F);
    awaitResult(4'd1, 64'hFF, "R9 or");
    grant();
  endtask

  task automatic testWakeup();
    doIssue(2'd0, 4'd12, 64'd0, 4'd0, 64'd4);
    broadcast(4'd13, 64'd999);
    for (int n = 0; n < 4; n++) begin
      check(dispValid == 1'b0 && resultReq == 1'b0, "R10 foreign tag ignored",
            64'({dispValid, resultReq}), 64'd0);
      @(negedge clk);
    end
    broadcast(4'd12, 64'd100);
    check(dispValid == 1'b1, "R4 dispatch after wakeup", 64'(dispValid), 64'd1);
    awaitResult(4'd1, 64'd104, "R4 captured value");
    grant();
  endtask

  task automatic testSameCycle();
    setIssue(2'd0, 4'd0, 64'd1, 4'd14, 64'd0);
    busValid = 1'b1; busTag = 4'd14; busData = 64'd50;
    @(negedge clk);
    issueValid = 1'b0; busValid = 1'b0;
    check(dispValid == 1'b1, "R5 captured at issue", 64'(dispValid), 64'd1);
    awaitResult(4'd1, 64'd51, "R5 value");
    grant();
  endtask

  task automatic testAgeAndStall();
    doIssue(2'd0, 4'd0, 64'd1, 4'd0, 64'd1);    // slot 0, ready
    doIssue(2'd0, 4'd9, 64'd0, 4'd0, 64'd3);    // slot 1, waits on 9
    awaitResult(4'd1, 64'd2, "R2 first slot");
    grant();
    doIssue(2'd1, 4'd9, 64'd0, 4'd0, 64'd1);    // slot 0 again, younger
    doIssue(2'd0, 4'd0, 64'd5, 4'd11, 64'd0);   // slot 2, waits on 11
    check(issueReady == 1'b0, "R2 full pool", 64'(issueReady), 64'd0);
    doIssue(2'd0, 4'd0, 64'd7, 4'd0, 64'd7);    // must be dropped
    check(issueReady == 1'b0, "R2 still full", 64'(issueReady), 64'd0);
    broadcast(4'd9, 64'd40);
    check(dispValid == 1'b1 && dispTag == 4'd2, "R6 oldest dispatches", 64'(dispTag), 64'd2);
    @(negedge clk);
    check(dispValid == 1'b0, "R7 no second dispatch", 64'(dispValid), 64'd0);
    awaitResult(4'd2, 64'd43, "R6 oldest result");
    check(issueReady == 1'b0, "R8 not freed before grant", 64'(issueReady), 64'd0);
    grant();
    check(issueReady == 1'b1, "R8 freed on grant", 64'(issueReady), 64'd1);
    awaitResult(4'd1, 64'd39, "R6 younger result");
    grant();
    broadcast(4'd11, 64'd6);
    awaitResult(4'd3, 64'd11, "R4 source B wakeup");
    grant();
    for (int n = 0; n < 6; n++) begin
      check(resultReq == 1'b0 && dispValid == 1'b0, "R2 dropped issue had no effect",
            64'({dispValid, resultReq}), 64'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; issueValid = 1'b0; issueOp = '0;
    issueTagA = '0; issueValA = '0; issueTagB = '0; issueValB = '0;
    busValid = 1'b0; busTag = '0; busData = '0; busGrant = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasicTiming();
    testOps();
    testWakeup();
    testSameCycle();
    testAgeAndStall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule